// File: doc/BRIEF.md
# Instruction Fetch Stage Controller

This block decides, once per clock, what the instruction fetch stage of a pipelined processor does. It may redirect the fetch address, hold the stage, spend a recovery cycle, or issue a fetch. It weighs redirect requests from the commit and decode stages, a flag saying the reorder buffer is still unwinding, four per-stage stall lines and the instruction-cache miss handshake. The requests are taken in a fixed priority order.

It owns the fetch address register and the following-address register, which always holds the fetch address plus one instruction. It drives a one-cycle fetch-enable strobe to the fetch-group logic, which answers in the same cycle with the address the next group starts at. It drives a cancel strobe to the instruction cache when a redirect overtakes an outstanding miss. It also sends single-cycle training pulses to the direction predictor and the branch target buffer when the commit stage reports a misprediction. The update ports have no ready: the storage behind them must accept a write in every cycle.

The commit stage redirects with the first priority and is the only source that trains the predictor. A decode redirect is dropped while the stage is already recovering from a redirect. Leaving the hold state or the recovery state always costs one cycle without a fetch.

Top module: `fetch_ctrl`

## Requirements
- R1: After reset the stage is running. The fetch address equals RESET_PC, the following address equals RESET_PC + INST_BYTES, both update ports are idle, and `fetch_en_o` is high in the first cycle when no request is present.
- R2: A commit redirect overrides every other input. `fetch_en_o` is low in that cycle, and one cycle later `pc_o` equals `cmt_target_i` and `npc_o` equals `cmt_target_i` + INST_BYTES.
- R3: With no commit redirect, `rob_busy_i` suppresses the fetch and leaves `pc_o` unchanged. The stage enters recovery.
- R4: A decode redirect with no commit redirect and no busy reorder buffer loads `dec_target_i` into `pc_o` (and the target plus INST_BYTES into `npc_o`) one cycle later, and the stage enters recovery. If the stage is already in recovery, the decode redirect is ignored and `pc_o` holds.
- R5: Outside a miss wait, any high bit of `stall_i` holds the stage: no fetch, and `pc_o` unchanged. Bit 0 is decode, bit 1 rename, bit 2 execute, bit 3 commit.
- R6: When the held stage sees all stall bits low, it spends exactly one cycle without a fetch, then fetches in the next cycle.
- R7: After any redirect, and after a cycle of a busy reorder buffer, there is exactly one cycle without a fetch when no request is present. The stage fetches in the cycle after that.
- R8: In a fetch cycle with `miss_i` low, `pc_o` takes `grp_next_pc_i` and `npc_o` takes `grp_next_pc_i` + INST_BYTES at the next edge.
- R9: A fetch cycle with `miss_i` high keeps `pc_o` and enters miss wait. Miss wait issues no fetch and ignores stall bits until `miss_done_i`. The cycle after `miss_done_i` is a fetch cycle.
- R10: `miss_cancel_o` is high exactly in a cycle that redirects (from commit or decode) while in miss wait, and low in every other cycle.
- R11: A commit redirect with `cmt_mispred_i` high raises `bp_upd_valid_o` and `btb_upd_valid_o` for exactly the next cycle. They carry `cmt_mis_pc_i`, `cmt_taken_i` and `cmt_target_i` as the target. No other input combination raises either valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmt_squash_i | input | 1 | Commit-stage redirect request |
| cmt_target_i | input | AW | Corrected fetch address from commit |
| cmt_mispred_i | input | 1 | Commit redirect stems from a branch misprediction |
| cmt_mis_pc_i | input | AW | Address of the mispredicted branch |
| cmt_taken_i | input | 1 | Resolved direction of that branch |
| rob_busy_i | input | 1 | Reorder buffer is still unwinding |
| dec_squash_i | input | 1 | Decode-stage redirect request |
| dec_target_i | input | AW | Fetch address from decode |
| stall_i | input | NSTALL | Per-stage hold lines (decode, rename, execute, commit) |
| miss_i | input | 1 | Cache reports a miss for this cycle's fetch |
| miss_done_i | input | 1 | Outstanding miss has been filled |
| grp_next_pc_i | input | AW | Address the next fetch group starts at |
| pc_o | output | AW | Current fetch address |
| npc_o | output | AW | Fetch address plus one instruction |
| fetch_en_o | output | 1 | Fetch is issued in this cycle |
| miss_cancel_o | output | 1 | Drop the outstanding cache miss |
| bp_upd_valid_o | output | 1 | Direction predictor training strobe |
| bp_upd_pc_o | output | AW | Branch address to train |
| bp_upd_taken_o | output | 1 | Outcome to train |
| btb_upd_valid_o | output | 1 | Target buffer write strobe |
| btb_upd_pc_o | output | AW | Branch address to write |
| btb_upd_target_o | output | AW | Target to write |

## Verification
`fetch_en_o` and `miss_cancel_o` are combinational from the registered state and the inputs of the same cycle. The bench therefore checks them shortly after driving inputs at the falling edge, before the next rising edge. `pc_o` and `npc_o` move at the edge that ends the deciding cycle, and the training strobes are registered once, so both are checked at the falling edge one cycle after the stimulus. Recovery costs are checked cycle by cycle: the idle cycle is observed first, then the fetch in the following cycle, so an extra or missing idle cycle is caught.

// File: rtl/fetch_ctrl_pkg.sv
package fetch_ctrl_pkg;

  // Operating states of the fetch stage
  typedef enum logic [2:0] {
    FS_RUN       = 3'd0,
    FS_BLOCK     = 3'd1,
    FS_SQUASH    = 3'd2,
    FS_MISS_WAIT = 3'd3,
    FS_MISS_DONE = 3'd4
  } fstate_e;

endpackage

// File: rtl/fetch_ctrl_arb.sv
module fetch_ctrl_arb
  import fetch_ctrl_pkg::*;
#(
  parameter int unsigned NSTALL = 4
) (
  input  fstate_e           state_i,
  input  logic              cmt_squash_i,
  input  logic              rob_busy_i,
  input  logic              dec_squash_i,
  input  logic [NSTALL-1:0] stall_i,
  input  logic              miss_i,
  input  logic              miss_done_i,
  output fstate_e           state_d_o,
  output logic              redir_o,
  output logic              redir_cmt_o,
  output logic              fetch_o,
  output logic              advance_o,
  output logic              cancel_o
);

  // Priority: commit redirect, busy reorder buffer, decode redirect,
  // miss wait, stall, recovery, fetch.
  always_comb begin
    state_d_o   = state_i;
    redir_o     = 1'b0;
    redir_cmt_o = 1'b0;
    fetch_o     = 1'b0;
    advance_o   = 1'b0;
    if (cmt_squash_i) begin
      redir_o     = 1'b1;
      redir_cmt_o = 1'b1;
      state_d_o   = FS_SQUASH;
    end else if (rob_busy_i) begin
      state_d_o = FS_SQUASH;
    end else if (dec_squash_i && (state_i != FS_SQUASH)) begin
      redir_o   = 1'b1;
      state_d_o = FS_SQUASH;
    end else if (state_i == FS_MISS_WAIT) begin
      if (miss_done_i) state_d_o = FS_MISS_DONE;
    end else if (|stall_i) begin
      state_d_o = FS_BLOCK;
    end else if ((state_i == FS_BLOCK) || (state_i == FS_SQUASH)) begin
      state_d_o = FS_RUN;
    end else begin
      fetch_o = 1'b1;
      if (miss_i) begin
        state_d_o = FS_MISS_WAIT;
      end else begin
        advance_o = 1'b1;
        state_d_o = FS_RUN;
      end
    end
    cancel_o = redir_o && (state_i == FS_MISS_WAIT);
  end

endmodule

// File: rtl/fetch_ctrl_pc.sv
module fetch_ctrl_pc #(
  parameter int unsigned     AW         = 32,
  parameter int unsigned     INST_BYTES = 4,
  parameter logic [AW-1:0]   RESET_PC   = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          redir_i,
  input  logic          redir_cmt_i,
  input  logic [AW-1:0] cmt_target_i,
  input  logic [AW-1:0] dec_target_i,
  input  logic          advance_i,
  input  logic [AW-1:0] grp_next_pc_i,
  output logic [AW-1:0] pc_o,
  output logic [AW-1:0] npc_o
);

  localparam logic [AW-1:0] STEP = AW'(INST_BYTES);

  logic [AW-1:0] load_val;
  logic          load_en;

  always_comb begin
    load_en  = redir_i || advance_i;
    if (redir_i) load_val = redir_cmt_i ? cmt_target_i : dec_target_i;
    else         load_val = grp_next_pc_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_o  <= RESET_PC;
      npc_o <= RESET_PC + STEP;
    end else if (load_en) begin
      pc_o  <= load_val;
      npc_o <= load_val + STEP;
    end
  end

endmodule

// File: rtl/fetch_ctrl_train.sv
module fetch_ctrl_train #(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_i,
  input  logic [AW-1:0] mis_pc_i,
  input  logic          taken_i,
  input  logic [AW-1:0] target_i,
  output logic          bp_valid_o,
  output logic [AW-1:0] bp_pc_o,
  output logic          bp_taken_o,
  output logic          btb_valid_o,
  output logic [AW-1:0] btb_pc_o,
  output logic [AW-1:0] btb_target_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bp_valid_o   <= 1'b0;
      btb_valid_o  <= 1'b0;
      bp_pc_o      <= '0;
      bp_taken_o   <= 1'b0;
      btb_pc_o     <= '0;
      btb_target_o <= '0;
    end else begin
      bp_valid_o  <= req_i;
      btb_valid_o <= req_i;
      if (req_i) begin
        bp_pc_o      <= mis_pc_i;
        bp_taken_o   <= taken_i;
        btb_pc_o     <= mis_pc_i;
        btb_target_o <= target_i;
      end
    end
  end

endmodule

// File: rtl/fetch_ctrl.sv
module fetch_ctrl
  import fetch_ctrl_pkg::*;
#(
  parameter int unsigned   AW         = 32,
  parameter int unsigned   INST_BYTES = 4,
  parameter int unsigned   NSTALL     = 4,
  parameter logic [AW-1:0] RESET_PC   = AW'(32'h0000_0100)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmt_squash_i,
  input  logic [AW-1:0]     cmt_target_i,
  input  logic              cmt_mispred_i,
  input  logic [AW-1:0]     cmt_mis_pc_i,
  input  logic              cmt_taken_i,
  input  logic              rob_busy_i,
  input  logic              dec_squash_i,
  input  logic [AW-1:0]     dec_target_i,
  input  logic [NSTALL-1:0] stall_i,
  input  logic              miss_i,
  input  logic              miss_done_i,
  input  logic [AW-1:0]     grp_next_pc_i,
  output logic [AW-1:0]     pc_o,
  output logic [AW-1:0]     npc_o,
  output logic              fetch_en_o,
  output logic              miss_cancel_o,
  output logic              bp_upd_valid_o,
  output logic [AW-1:0]     bp_upd_pc_o,
  output logic              bp_upd_taken_o,
  output logic              btb_upd_valid_o,
  output logic [AW-1:0]     btb_upd_pc_o,
  output logic [AW-1:0]     btb_upd_target_o
);

  fstate_e state_q, state_d;
  logic    redir, redir_cmt, advance, train_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= FS_RUN;
    else        state_q <= state_d;
  end

  fetch_ctrl_arb #(.NSTALL(NSTALL)) arb_i (
    .state_i      (state_q),
    .cmt_squash_i (cmt_squash_i),
    .rob_busy_i   (rob_busy_i),
    .dec_squash_i (dec_squash_i),
    .stall_i      (stall_i),
    .miss_i       (miss_i),
    .miss_done_i  (miss_done_i),
    .state_d_o    (state_d),
    .redir_o      (redir),
    .redir_cmt_o  (redir_cmt),
    .fetch_o      (fetch_en_o),
    .advance_o    (advance),
    .cancel_o     (miss_cancel_o)
  );

  fetch_ctrl_pc #(.AW(AW), .INST_BYTES(INST_BYTES), .RESET_PC(RESET_PC)) pc_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .redir_i       (redir),
    .redir_cmt_i   (redir_cmt),
    .cmt_target_i  (cmt_target_i),
    .dec_target_i  (dec_target_i),
    .advance_i     (advance),
    .grp_next_pc_i (grp_next_pc_i),
    .pc_o          (pc_o),
    .npc_o         (npc_o)
  );

  assign train_req = cmt_squash_i && cmt_mispred_i;

  fetch_ctrl_train #(.AW(AW)) train_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_i        (train_req),
    .mis_pc_i     (cmt_mis_pc_i),
    .taken_i      (cmt_taken_i),
    .target_i     (cmt_target_i),
    .bp_valid_o   (bp_upd_valid_o),
    .bp_pc_o      (bp_upd_pc_o),
    .bp_taken_o   (bp_upd_taken_o),
    .btb_valid_o  (btb_upd_valid_o),
    .btb_pc_o     (btb_upd_pc_o),
    .btb_target_o (btb_upd_target_o)
  );

endmodule

// File: rtl/fetch_ctrl_chk.sv
module fetch_ctrl_chk #(
  parameter int unsigned AW         = 32,
  parameter int unsigned INST_BYTES = 4,
  parameter int unsigned NSTALL     = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmt_squash_i,
  input logic [AW-1:0]     cmt_target_i,
  input logic              cmt_mispred_i,
  input logic [AW-1:0]     cmt_mis_pc_i,
  input logic              rob_busy_i,
  input logic              dec_squash_i,
  input logic [NSTALL-1:0] stall_i,
  input logic [AW-1:0]     pc_o,
  input logic [AW-1:0]     npc_o,
  input logic              fetch_en_o,
  input logic              miss_cancel_o,
  input logic              bp_upd_valid_o,
  input logic [AW-1:0]     bp_upd_pc_o,
  input logic              btb_upd_valid_o,
  input logic [AW-1:0]     btb_upd_target_o
);

  localparam logic [AW-1:0] STEP = AW'(INST_BYTES);

  AST_CMT_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_squash_i |=> (pc_o == $past(cmt_target_i)) && (npc_o == AW'($past(cmt_target_i) + STEP))); // R2
  AST_CMT_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_squash_i |-> !fetch_en_o); // R2
  AST_ROB_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    rob_busy_i |-> !fetch_en_o); // R3
  AST_ROB_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rob_busy_i && !cmt_squash_i) |=> $stable(pc_o)); // R3
  AST_STALL_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (|stall_i) |-> !fetch_en_o); // R5
  AST_RECOVERY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmt_squash_i || (dec_squash_i && !rob_busy_i && miss_cancel_o)) |=> !fetch_en_o); // R7
  AST_TRAIN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmt_squash_i && cmt_mispred_i) |=> bp_upd_valid_o && btb_upd_valid_o &&
      (bp_upd_pc_o == $past(cmt_mis_pc_i)) && (btb_upd_target_o == $past(cmt_target_i))); // R11
  AST_TRAIN_ONLY_CMT: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmt_squash_i && cmt_mispred_i) |=> !bp_upd_valid_o && !btb_upd_valid_o); // R11
  AST_CANCEL_ON_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    miss_cancel_o |-> (cmt_squash_i || dec_squash_i) && !fetch_en_o); // R10

endmodule

bind fetch_ctrl fetch_ctrl_chk #(.AW(AW), .INST_BYTES(INST_BYTES), .NSTALL(NSTALL)) chk_i (
  .clk              (clk),
  .rst_n            (rst_n),
  .cmt_squash_i     (cmt_squash_i),
  .cmt_target_i     (cmt_target_i),
  .cmt_mispred_i    (cmt_mispred_i),
  .cmt_mis_pc_i     (cmt_mis_pc_i),
  .rob_busy_i       (rob_busy_i),
  .dec_squash_i     (dec_squash_i),
  .stall_i          (stall_i),
  .pc_o             (pc_o),
  .npc_o            (npc_o),
  .fetch_en_o       (fetch_en_o),
  .miss_cancel_o    (miss_cancel_o),
  .bp_upd_valid_o   (bp_upd_valid_o),
  .bp_upd_pc_o      (bp_upd_pc_o),
  .btb_upd_valid_o  (btb_upd_valid_o),
  .btb_upd_target_o (btb_upd_target_o)
);

// File: tb/fetch_ctrl_tb_top.sv
module fetch_ctrl_tb_top;

  localparam int unsigned AW   = 16;
  localparam int unsigned STEP = 4;
  localparam logic [AW-1:0] RST_PC = 16'h0100;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmt_squash, cmt_mispred, cmt_taken, rob_busy, dec_squash, miss, miss_done;
  logic [AW-1:0] cmt_target, cmt_mis_pc, dec_target, grp_next;
  logic [3:0]    stall;
  logic [AW-1:0] pc, npc, bp_pc, btb_pc, btb_tgt;
  logic          fetch_en, cancel, bp_valid, bp_taken, btb_valid;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  fetch_ctrl #(.AW(AW), .INST_BYTES(STEP), .NSTALL(4), .RESET_PC(RST_PC)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cmt_squash_i(cmt_squash), .cmt_target_i(cmt_target), .cmt_mispred_i(cmt_mispred),
    .cmt_mis_pc_i(cmt_mis_pc), .cmt_taken_i(cmt_taken), .rob_busy_i(rob_busy),
    .dec_squash_i(dec_squash), .dec_target_i(dec_target), .stall_i(stall),
    .miss_i(miss), .miss_done_i(miss_done), .grp_next_pc_i(grp_next),
    .pc_o(pc), .npc_o(npc), .fetch_en_o(fetch_en), .miss_cancel_o(cancel),
    .bp_upd_valid_o(bp_valid), .bp_upd_pc_o(bp_pc), .bp_upd_taken_o(bp_taken),
    .btb_upd_valid_o(btb_valid), .btb_upd_pc_o(btb_pc), .btb_upd_target_o(btb_tgt)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle();
    cmt_squash = 0; cmt_mispred = 0; cmt_taken = 0; rob_busy = 0; dec_squash = 0;
    miss = 0; miss_done = 0; stall = 4'h0;
    cmt_target = 16'h0; cmt_mis_pc = 16'h0; dec_target = 16'h0; grp_next = 16'h0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic settle();
    #1;
  endtask

  // bench state codes: 0 run, 1 hold, 2 recovery, 3 miss wait, 4 miss complete
  task automatic enter(input int st, input logic [AW-1:0] t);
    idle(); cmt_squash = 1; cmt_target = t; tick();
    idle();
    if (st != 2) begin
      tick();
      if (st == 1) begin stall = 4'h1; tick(); idle(); end
      if (st >= 3) begin miss = 1; tick(); idle(); end
      if (st == 4) begin miss_done = 1; tick(); idle(); end
    end
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    // R1 reset state
    chk("R1 pc", 32'(pc), 32'(RST_PC));
    chk("R1 npc", 32'(npc), 32'(RST_PC + STEP));
    chk("R1 bp_valid", 32'(bp_valid), 0);
    chk("R1 btb_valid", 32'(btb_valid), 0);
    chk("R1 fetch_en", 32'(fetch_en), 1);
    chk("R1 cancel", 32'(cancel), 0);

    // R8 fetch advances to the group's next address
    enter(0, 16'h1000);
    for (int i = 0; i < 8; i++) begin
      logic [AW-1:0] g;
      g = 16'h2000 + AW'(i * 24);
      grp_next = g; settle();
      chk("R8 fetch_en", 32'(fetch_en), 1);
      tick();
      chk("R8 pc", 32'(pc), 32'(g));
      chk("R8 npc", 32'(npc), 32'(g + STEP));
    end

    // R2/R7/R10 commit redirect from every state, with and without competing inputs
    for (int st = 0; st < 5; st++) begin
      for (int junk = 0; junk < 2; junk++) begin
        logic [AW-1:0] t;
        t = 16'h4000 + AW'(st * 64 + junk * 16);
        enter(st, 16'h3000);
        cmt_squash = 1; cmt_target = t;
        if (junk == 1) begin
          rob_busy = 1; dec_squash = 1; dec_target = 16'h5000; stall = 4'hF;
          miss = 1; miss_done = 1; grp_next = 16'h5500;
        end
        settle();
        chk("R2 fetch_en", 32'(fetch_en), 0);
        chk("R10 cancel", 32'(cancel), (st == 3) ? 1 : 0);
        tick(); idle();
        chk("R2 pc", 32'(pc), 32'(t));
        chk("R2 npc", 32'(npc), 32'(t + STEP));
        settle();
        chk("R7 recovery idle", 32'(fetch_en), 0);
        tick(); settle();
        chk("R7 fetch after recovery", 32'(fetch_en), 1);
      end
    end

    // R11 predictor training from commit mispredictions
    for (int tk = 0; tk < 2; tk++) begin
      enter(0, 16'h0A00);
      cmt_squash = 1; cmt_mispred = 1; cmt_taken = tk[0];
      cmt_mis_pc = 16'h0770 + AW'(tk * 4); cmt_target = 16'h0880 + AW'(tk * 8);
      tick(); idle();
      chk("R11 bp_valid", 32'(bp_valid), 1);
      chk("R11 bp_pc", 32'(bp_pc), 32'(16'h0770 + tk * 4));
      chk("R11 bp_taken", 32'(bp_taken), tk);
      chk("R11 btb_valid", 32'(btb_valid), 1);
      chk("R11 btb_pc", 32'(btb_pc), 32'(16'h0770 + tk * 4));
      chk("R11 btb_tgt", 32'(btb_tgt), 32'(16'h0880 + tk * 8));
      tick();
      chk("R11 bp_valid single", 32'(bp_valid), 0);
      chk("R11 btb_valid single", 32'(btb_valid), 0);
    end
    enter(0, 16'h0A00);
    cmt_squash = 1; cmt_target = 16'h0B00; cmt_mis_pc = 16'h0B10;
    tick(); idle();
    chk("R11 no train without mispred", 32'(bp_valid | btb_valid), 0);
    enter(0, 16'h0A00);
    dec_squash = 1; dec_target = 16'h0C00; cmt_mispred = 1; cmt_mis_pc = 16'h0C10;
    tick(); idle();
    chk("R11 no train from decode", 32'(bp_valid | btb_valid), 0);

    // R3 busy reorder buffer
    for (int st = 0; st < 5; st++) begin
      if (st != 2) begin
        enter(st, 16'h6000);
        rob_busy = 1; grp_next = 16'h7000; stall = 4'h0;
        settle();
        chk("R3 fetch_en", 32'(fetch_en), 0);
        chk("R10 no cancel on rob", 32'(cancel), 0);
        tick(); idle();
        chk("R3 pc hold", 32'(pc), 32'h6000);
        settle();
        chk("R7 idle after rob", 32'(fetch_en), 0);
        tick(); settle();
        chk("R7 fetch after rob", 32'(fetch_en), 1);
      end
    end

    // R4 decode redirect outside recovery
    for (int st = 0; st < 5; st++) begin
      if (st != 2) begin
        logic [AW-1:0] t;
        t = 16'h8000 + AW'(st * 32);
        enter(st, 16'h6100);
        dec_squash = 1; dec_target = t; grp_next = 16'h7100;
        settle();
        chk("R4 fetch_en", 32'(fetch_en), 0);
        chk("R10 cancel dec", 32'(cancel), (st == 3) ? 1 : 0);
        tick(); idle();
        chk("R4 pc", 32'(pc), 32'(t));
        chk("R4 npc", 32'(npc), 32'(t + STEP));
        settle();
        chk("R7 idle after dec", 32'(fetch_en), 0);
        tick(); settle();
        chk("R7 fetch after dec", 32'(fetch_en), 1);
      end
    end
    // R4 decode redirect ignored during recovery
    for (int s = 0; s < 2; s++) begin
      enter(2, 16'h9000);
      dec_squash = 1; dec_target = 16'h9800; stall = (s == 1) ? 4'h2 : 4'h0;
      settle();
      chk("R4 ignored fetch_en", 32'(fetch_en), 0);
      tick(); idle();
      chk("R4 ignored pc", 32'(pc), 32'h9000);
      settle();
      chk("R4 ignored next", 32'(fetch_en), (s == 1) ? 0 : 1);
    end

    // R5/R6 every stall pattern
    for (int s = 1; s < 16; s++) begin
      enter(0, 16'hA000);
      stall = 4'(s); grp_next = 16'hB000;
      settle();
      chk("R5 fetch_en", 32'(fetch_en), 0);
      tick(); settle();
      chk("R5 held fetch_en", 32'(fetch_en), 0);
      tick(); idle();
      chk("R5 pc hold", 32'(pc), 32'hA000);
      settle();
      chk("R6 release idle", 32'(fetch_en), 0);
      tick(); settle();
      chk("R6 fetch after release", 32'(fetch_en), 1);
    end

    // R9 miss handling
    enter(0, 16'hC000);
    miss = 1; grp_next = 16'hC100; settle();
    chk("R9 miss fetch_en", 32'(fetch_en), 1);
    tick(); idle();
    chk("R9 pc hold on miss", 32'(pc), 32'hC000);
    stall = 4'hF; settle();
    chk("R9 wait no fetch", 32'(fetch_en), 0);
    tick(); stall = 4'h0; miss_done = 1; settle();
    chk("R9 done cycle no fetch", 32'(fetch_en), 0);
    tick(); idle(); grp_next = 16'hC200; settle();
    chk("R9 refetch", 32'(fetch_en), 1);
    tick();
    chk("R9 pc after refetch", 32'(pc), 32'hC200);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule